// File: doc/BRIEF.md
# Pin Interrupt Selector with Enable

This block turns a wide vector of GPIO interrupt lines into a smaller set of interrupt channels. Each channel holds a select field that picks one line out of the vector, a 2-bit sense code that chooses rising edge, falling edge, high level or low level, a status flag, and an enable bit. The enable bit sits at the top of the select field. A channel's output is raised while its flag is set and the channel is enabled. The output goes on to a parent interrupt controller.

Software reaches the block over a simple 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. The register window starts at a parameterised offset from the unit base. Inside the window there are four kinds of register: a read-only status word, a write-one-to-clear word, the sense words, and the packed select/enable words. Changing the select field would normally look like a change on the line. To stop this, the edge detector's history is reloaded from the newly selected line on the edge where the select word is written. A select/enable write therefore never produces a false edge. Software can still write the clear word straight afterwards.

Top module: `pint_router`

## Requirements
- R1: After synchronous reset every select field, enable bit, sense code (0) and status flag is zero, and `irq_out` is all low.
- R2: The low FW-1 bits of a channel's field choose line index `sel`. A value above MAX_SEL selects a constant low line.
- R3: Sense code 0 sets the flag on a 0-to-1 change of the selected line. Code 1 sets it on a 1-to-0 change. The line is seen on one clock edge and the flag is set on the next.
- R4: With sense code 2 the flag takes the value of the selected line on every edge. With code 3 it takes the inverse. A clear write has no effect in these modes.
- R5: Writing 1 to bit n of the clear word (offset 0x24) clears flag n only when the flag is set and channel n is in edge mode (code 0 or 1). If an edge arrives in the same cycle, the edge wins. Zero bits have no effect.
- R6: Bit FW-1 of a channel's field is its enable. `irq_out[n]` equals flag n AND enable n.
- R7: While a channel is disabled its flag holds its value: no edge, level change or clear write alters it.
- R8: On a write to a select word, the history of every channel in that word is reloaded from its newly selected line. Reselecting a line therefore never sets an edge-mode flag by itself.
- R9: The register map is relative to BASE_OFS. Status at 0x20 is read-only (bit n = flag n). Clear at 0x24 reads zero. Sense word k is at 0x28+4k and holds channel 16k+j in bits [2j+1:2j]. Select word k is at 0x30+4k and holds channel k*CPR+j in bits [j*FW+FW-1:j*FW], where CPR=32/FW. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| line_in | input | MAX_SEL+1 | GPIO interrupt lines |
| irq_out | output | NCH | Per-channel interrupt outputs |

## Verification
The bench rewrites a channel's select word so that it moves from a low line to a high line. A design without the history reload would raise a rising-edge interrupt that no pin caused. It writes the clear word in level mode, while a channel is disabled, and in the same cycle as a new edge. A wrong design would drop a live level flag, unfreeze a disabled channel, or lose an edge. Further tests cover a select value above the legal maximum and a channel in the second sense word. Writes to the register offsets without the base added are also checked, and a decoder that ignores the base would act on them.

// File: rtl/pint_pkg.sv
package pint_pkg;

    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    typedef struct packed {
        logic   en;
        sense_e sense;
    } chan_mode_t;

    // Word offsets inside the channel register window
    localparam int OFS_STAT  = 32'h20;
    localparam int OFS_CLR   = 32'h24;
    localparam int OFS_SENSE = 32'h28;
    localparam int OFS_SEL   = 32'h30;

    function automatic logic is_edge_mode(sense_e s);
        return (s == SNS_RISE) || (s == SNS_FALL);
    endfunction

endpackage

// File: rtl/pint_regfile.sv
module pint_regfile
    import pint_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int FW       = 8,
    parameter int ADDR_W   = 12,
    parameter int BASE_OFS = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NCH-1:0]                status_in,
    output chan_mode_t [NCH-1:0]          mode_o,
    output logic [NCH-1:0][FW-2:0]        sel_o,
    output logic [NCH-1:0]                sel_wr_o,
    output logic [NCH-1:0][FW-2:0]        sel_new_o,
    output logic [NCH-1:0]                clr_o
);

    localparam int CPR    = 32 / FW;
    localparam int NSELR  = NCH / CPR;
    localparam int NSENSE = NCH / 16;
    localparam int SW     = FW - 1;

    logic [ADDR_W-1:0]       rel;
    logic                    stat_hit;
    logic                    clr_hit;
    logic [NSENSE-1:0]       sns_hit;
    logic [NSELR-1:0]        sel_hit;
    logic [NCH-1:0][FW-1:0]  field_q;
    sense_e [NCH-1:0]        sense_q;

    assign rel      = reg_addr - ADDR_W'(BASE_OFS);
    assign stat_hit = (rel == ADDR_W'(OFS_STAT));
    assign clr_hit  = (rel == ADDR_W'(OFS_CLR));

    for (genvar k = 0; k < NSENSE; k++) begin : g_sns_dec
        assign sns_hit[k] = (rel == ADDR_W'(OFS_SENSE + 4 * k));
    end

    for (genvar k = 0; k < NSELR; k++) begin : g_sel_dec
        assign sel_hit[k] = (rel == ADDR_W'(OFS_SEL + 4 * k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
            for (int n = 0; n < NCH; n++) sense_q[n] <= SNS_RISE;
        end else if (reg_we) begin
            for (int n = 0; n < NCH; n++) begin
                if (sel_hit[n / CPR])
                    field_q[n] <= reg_wdata[(n % CPR) * FW +: FW];
                if (sns_hit[n / 16])
                    sense_q[n] <= sense_e'(reg_wdata[(n % 16) * 2 +: 2]);
            end
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan_out
        assign mode_o[n].en    = field_q[n][FW-1];
        assign mode_o[n].sense = sense_q[n];
        assign sel_o[n]        = field_q[n][SW-1:0];
        assign sel_wr_o[n]     = reg_we & sel_hit[n / CPR];
        assign sel_new_o[n]    = reg_wdata[(n % CPR) * FW +: SW];
        assign clr_o[n]        = reg_we & clr_hit & reg_wdata[n];
    end

    always_comb begin
        reg_rdata = '0;
        if (stat_hit) reg_rdata = 32'(status_in);
        for (int k = 0; k < NSENSE; k++) begin
            if (sns_hit[k]) begin
                for (int j = 0; j < 16; j++)
                    reg_rdata[j * 2 +: 2] = sense_q[k * 16 + j];
            end
        end
        for (int k = 0; k < NSELR; k++) begin
            if (sel_hit[k]) begin
                for (int j = 0; j < CPR; j++)
                    reg_rdata[j * FW +: FW] = field_q[k * CPR + j];
            end
        end
    end

endmodule

// File: rtl/pint_channel.sv
module pint_channel
    import pint_pkg::*;
#(
    parameter int FW   = 8,
    parameter int PADW = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PADW-1:0] lines,
    input  chan_mode_t      mode,
    input  logic [FW-2:0]   sel,
    input  logic            sel_wr,
    input  logic [FW-2:0]   sel_new,
    input  logic            clr,
    output logic            pick_o,
    output logic            status_o,
    output logic            irq_o
);

    logic cur;
    logic hist_q;
    logic flag_q;
    logic flag_d;
    logic rise;
    logic fall;

    // lines above the legal select range are tied low by the caller
    assign cur  = lines[sel];
    assign rise = cur & ~hist_q;
    assign fall = ~cur & hist_q;

    always_comb begin
        flag_d = flag_q;
        if (mode.en) begin
            unique case (mode.sense)
                SNS_RISE: flag_d = rise ? 1'b1 : ((clr && flag_q) ? 1'b0 : flag_q);
                SNS_FALL: flag_d = fall ? 1'b1 : ((clr && flag_q) ? 1'b0 : flag_q);
                SNS_HIGH: flag_d = cur;
                SNS_LOW:  flag_d = ~cur;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            hist_q <= sel_wr ? lines[sel_new] : cur;
            flag_q <= flag_d;
        end
    end

    assign pick_o   = cur;
    assign status_o = flag_q;
    assign irq_o    = flag_q & mode.en;

endmodule

// File: rtl/pint_router.sv
module pint_router
    import pint_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int FW       = 8,
    parameter int MAX_SEL  = 32'h55,
    parameter int ADDR_W   = 12,
    parameter int BASE_OFS = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [MAX_SEL:0]   line_in,
    output logic [NCH-1:0]     irq_out
);

    localparam int NLINES = MAX_SEL + 1;
    localparam int PADW   = 2 ** (FW - 1);

    logic [PADW-1:0]          padded;
    chan_mode_t [NCH-1:0]     mode_vec;
    logic [NCH-1:0][FW-2:0]   sel_vec;
    logic [NCH-1:0]           sel_wr_vec;
    logic [NCH-1:0][FW-2:0]   sel_new_vec;
    logic [NCH-1:0]           clr_vec;
    logic [NCH-1:0]           status_vec;
    logic [NCH-1:0]           pick_vec;
    logic [NCH-1:0]           en_vec;
    logic [NCH-1:0][1:0]      sense_vec;

    // select codes past the last line see a constant low
    assign padded = PADW'(line_in[NLINES-1:0]);

    pint_regfile #(
        .NCH(NCH), .FW(FW), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_in (status_vec),
        .mode_o    (mode_vec),
        .sel_o     (sel_vec),
        .sel_wr_o  (sel_wr_vec),
        .sel_new_o (sel_new_vec),
        .clr_o     (clr_vec)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pint_channel #(.FW(FW), .PADW(PADW)) chan_i (
            .clk      (clk),
            .rst      (rst),
            .lines    (padded),
            .mode     (mode_vec[n]),
            .sel      (sel_vec[n]),
            .sel_wr   (sel_wr_vec[n]),
            .sel_new  (sel_new_vec[n]),
            .clr      (clr_vec[n]),
            .pick_o   (pick_vec[n]),
            .status_o (status_vec[n]),
            .irq_o    (irq_out[n])
        );
        assign en_vec[n]    = mode_vec[n].en;
        assign sense_vec[n] = mode_vec[n].sense;
    end

endmodule

// File: rtl/pint_router_chk.sv
module pint_router_chk #(
    parameter int NCH      = 32,
    parameter int ADDR_W   = 12,
    parameter int BASE_OFS = 0
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [31:0]          reg_rdata,
    input logic [NCH-1:0]       irq_out,
    input logic [NCH-1:0]       en_vec,
    input logic [NCH-1:0]       status_vec,
    input logic [NCH-1:0]       pick_vec,
    input logic [NCH-1:0]       clr_vec,
    input logic [NCH-1:0][1:0]  sense_vec
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> irq_out == '0);

    // R9
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(BASE_OFS + 32'h24)) |-> reg_rdata == 32'h0);

    for (genvar n = 0; n < NCH; n++) begin : g_p
        // R7
        frozen_off_chk: assert property (@(posedge clk) disable iff (rst)
            !en_vec[n] |=> $stable(status_vec[n]));

        // R5
        edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (en_vec[n] && !sense_vec[n][1] && status_vec[n] && !clr_vec[n])
            |=> status_vec[n]);

        // R4
        level_high_chk: assert property (@(posedge clk) disable iff (rst)
            (en_vec[n] && sense_vec[n] == 2'd2) |=> status_vec[n] == $past(pick_vec[n]));

        // R4
        level_low_chk: assert property (@(posedge clk) disable iff (rst)
            (en_vec[n] && sense_vec[n] == 2'd3) |=> status_vec[n] == !$past(pick_vec[n]));
    end

endmodule

bind pint_router pint_router_chk #(
    .NCH(NCH), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .en_vec     (en_vec),
    .status_vec (status_vec),
    .pick_vec   (pick_vec),
    .clr_vec    (clr_vec),
    .sense_vec  (sense_vec)
);

// File: tb/pint_router_tb.sv
module pint_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH      = 32;
    localparam int FW       = 8;
    localparam int MAX_SEL  = 32'h55;
    localparam int ADDR_W   = 12;
    localparam int BASE     = 32'h800;
    localparam int NLINES   = MAX_SEL + 1;
    localparam int CPR      = 32 / FW;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + 32'h20);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + 32'h24);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NLINES-1:0] lines = '0;
    logic [NCH-1:0]    irq_out;

    int total = 0;
    int bad = 0;

    // bench model
    logic [FW-1:0] m_field [NCH];
    logic [1:0]    m_sense [NCH];
    logic          m_prev  [NCH];
    logic          m_st    [NCH];
    // shadows for building register words
    logic [FW-1:0] sh_field [NCH];
    logic [1:0]    sh_sense [NCH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pint_router #(
        .NCH(NCH), .FW(FW), .MAX_SEL(MAX_SEL), .ADDR_W(ADDR_W), .BASE_OFS(BASE)
    ) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(lines), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic mline(input int s);
        return (s <= MAX_SEL) ? lines[s] : 1'b0;
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] v = '0;
        for (int n = 0; n < NCH; n++) v[n] = m_st[n];
        return v;
    endfunction

    function automatic logic [NCH-1:0] m_irq();
        logic [NCH-1:0] v;
        for (int n = 0; n < NCH; n++) v[n] = m_st[n] & m_field[n][FW-1];
        return v;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NCH; n++) begin
            m_field[n] = '0; m_sense[n] = '0; m_prev[n] = 1'b0; m_st[n] = 1'b0;
            sh_field[n] = '0; sh_sense[n] = '0;
        end
    endtask

    // one clock with the given register access; model advanced alongside
    task automatic step(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [FW-1:0] nf [NCH];
        logic [1:0]    ns [NCH];
        logic          np [NCH];
        logic          nst[NCH];
        reg_we = we; reg_addr = a; reg_wdata = d;
        for (int n = 0; n < NCH; n++) begin
            logic cur, en, clr;
            cur = mline(int'(m_field[n][FW-2:0]));
            en  = m_field[n][FW-1];
            clr = we && (a == A_CLR) && d[n];
            nst[n] = m_st[n];
            if (en) begin
                case (m_sense[n])
                    2'd0: nst[n] = (cur && !m_prev[n]) ? 1'b1 : ((clr && m_st[n]) ? 1'b0 : m_st[n]);
                    2'd1: nst[n] = (!cur && m_prev[n]) ? 1'b1 : ((clr && m_st[n]) ? 1'b0 : m_st[n]);
                    2'd2: nst[n] = cur;
                    default: nst[n] = !cur;
                endcase
            end
            np[n] = cur;
            nf[n] = m_field[n];
            ns[n] = m_sense[n];
            if (we && a == ADDR_W'(BASE + 32'h30 + 4 * (n / CPR))) begin
                nf[n] = d[(n % CPR) * FW +: FW];
                np[n] = mline(int'(nf[n][FW-2:0]));
            end
            if (we && a == ADDR_W'(BASE + 32'h28 + 4 * (n / 16)))
                ns[n] = d[(n % 16) * 2 +: 2];
        end
        @(posedge clk);
        for (int n = 0; n < NCH; n++) begin
            m_field[n] = nf[n]; m_sense[n] = ns[n]; m_prev[n] = np[n]; m_st[n] = nst[n];
        end
        #1;
        chk("R6 irq_out vs model", 32'(irq_out), 32'(m_irq()));
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        reg_we = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_sel(input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < CPR; j++) w[j * FW +: FW] = sh_field[k * CPR + j];
        step(1'b1, ADDR_W'(BASE + 32'h30 + 4 * k), w);
    endtask

    task automatic wr_sense(input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 16; j++) w[j * 2 +: 2] = sh_sense[k * 16 + j];
        step(1'b1, ADDR_W'(BASE + 32'h28 + 4 * k), w);
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) step(1'b0, '0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_we = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd4711));
        do_reset();

        // R1 reset state
        chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd(A_STAT, v);                          chk("R1 status after reset", v, 32'h0);
        rd(ADDR_W'(BASE + 32'h30), v);          chk("R1 select word after reset", v, 32'h0);
        rd(ADDR_W'(BASE + 32'h2C), v);          chk("R1 sense word after reset", v, 32'h0);

        // R3 rising edge on ch0, line 5
        lines[5] = 1'b0;
        sh_field[0] = {1'b1, 7'd5};
        wr_sel(0);
        lines[5] = 1'b1;
        idle(1);
        chk("R3 rising edge sets ch0", 32'(irq_out[0]), 32'h1);
        rd(A_STAT, v);                          chk("R9 status bit0 set", v & 32'h1, 32'h1);

        // R5 clear edge flag
        step(1'b1, A_CLR, 32'h1);
        chk("R5 clear drops ch0", 32'(irq_out[0]), 32'h0);

        // R3 falling edge on ch1, line 7
        lines[7] = 1'b1;
        sh_sense[1] = 2'd1; wr_sense(0);
        sh_field[1] = {1'b1, 7'd7}; wr_sel(0);
        lines[7] = 1'b0;
        idle(1);
        chk("R3 falling edge sets ch1", 32'(irq_out[1]), 32'h1);

        // R8 reselect low line then high line: no false edge
        lines[9] = 1'b0;
        sh_field[0] = {1'b1, 7'd9}; wr_sel(0);
        idle(1);
        sh_field[0] = {1'b1, 7'd5}; wr_sel(0);
        idle(2);
        chk("R8 reselect to high line gives no edge", 32'(irq_out[0]), 32'h0);

        // R4 level high ch2, line 11
        lines[11] = 1'b1;
        sh_sense[2] = 2'd2; wr_sense(0);
        sh_field[2] = {1'b1, 7'd11}; wr_sel(0);
        idle(1);
        chk("R4 level high follows line", 32'(irq_out[2]), 32'h1);
        step(1'b1, A_CLR, 32'h4);
        chk("R4 clear ignored in level mode", 32'(irq_out[2]), 32'h1);
        lines[11] = 1'b0;
        idle(1);
        chk("R4 level high drops with line", 32'(irq_out[2]), 32'h0);

        // R4 level low ch17 in second sense word, line 20
        lines[20] = 1'b1;
        sh_sense[17] = 2'd3; wr_sense(1);
        sh_field[17] = {1'b1, 7'd20}; wr_sel(4);
        idle(1);
        chk("R4 level low with line high", 32'(irq_out[17]), 32'h0);
        lines[20] = 1'b0;
        idle(1);
        chk("R4 level low with line low", 32'(irq_out[17]), 32'h1);
        rd(ADDR_W'(BASE + 32'h2C), v);          chk("R9 sense word 1 layout", v, 32'h0000000C);

        // R2 out-of-range select reads constant low
        sh_sense[3] = 2'd3; wr_sense(0);
        sh_field[3] = {1'b1, 7'd100}; wr_sel(0);
        idle(1);
        chk("R2 select above max reads low", 32'(irq_out[3]), 32'h1);
        rd(ADDR_W'(BASE + 32'h30), v);
        chk("R9 select word 0 layout", v, 32'hE48B8785);

        // R7 disabled channel keeps its flag
        lines[5] = 1'b0; idle(1);
        lines[5] = 1'b1; idle(1);
        chk("R3 ch0 set again", 32'(irq_out[0]), 32'h1);
        sh_field[0] = {1'b0, 7'd5}; wr_sel(0);
        chk("R6 disabled ch0 output low", 32'(irq_out[0]), 32'h0);
        step(1'b1, A_CLR, 32'h1);
        rd(A_STAT, v);                          chk("R7 clear ignored while disabled", v & 32'h1, 32'h1);
        sh_field[2] = {1'b0, 7'd11}; wr_sel(0);
        lines[11] = 1'b1; idle(2);
        rd(A_STAT, v);                          chk("R7 level flag frozen while disabled", v & 32'h4, 32'h0);

        // R5 edge and clear in the same cycle: edge wins
        sh_field[0] = {1'b1, 7'd5}; wr_sel(0);
        step(1'b1, A_CLR, 32'h1);
        lines[5] = 1'b0; idle(1);
        lines[5] = 1'b1;
        step(1'b1, A_CLR, 32'h1);
        chk("R5 edge beats clear", 32'(irq_out[0]), 32'h1);

        // R9 base offset honoured, clear reads zero, unmapped reads zero
        step(1'b1, ADDR_W'(32'h024), 32'hFFFF_FFFF);
        rd(A_STAT, v);                          chk("R9 write without base ignored", v, m_status());
        rd(A_CLR, v);                           chk("R9 clear word reads zero", v, 32'h0);
        rd(ADDR_W'(BASE + 32'h3FC), v);         chk("R9 unmapped reads zero", v, 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int op;
            for (int b = 0; b < NLINES; b++)
                if ($urandom % 8 == 0) lines[b] = ~lines[b];
            op = int'($urandom % 10);
            if (op == 0) begin
                step(1'b1, A_CLR, $urandom);
            end else if (op == 1) begin
                step(1'b1, ADDR_W'(BASE + 32'h28 + 4 * ($urandom % 2)), $urandom);
            end else if (op == 2) begin
                step(1'b1, ADDR_W'(BASE + 32'h30 + 4 * ($urandom % (NCH / CPR))), $urandom);
            end else begin
                step(1'b0, '0, '0);
            end
            if (i % 4 == 0) begin
                rd(A_STAT, v);
                chk("R3 R4 R5 status readback vs model", v, m_status());
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule